// File: doc/BRIEF.md
# Processor IO Port with Memory Bank Controls

This block is a byte-wide bidirectional port that a small processor reaches through two memory-mapped registers. The register at offset 0 sets, bit by bit, whether each port line is an output (1) or an input (0). The register at offset 1 holds the port value. A write to the value register only changes the lines that are outputs. Every other line keeps what it held before.

The three lowest value bits also serve as memory-configuration controls. The block decodes them into paired ROM/RAM and IO/character-ROM select flags for three address windows. An external address decoder uses these flags to choose which device answers in each window.

The processor side is a plain synchronous bus. A write takes effect on the rising clock edge when chip select and write enable are both high. Read data is combinational from the address and the current register contents. No data stream flows through the block, so it has no valid/ready handshake and no back-pressure. Reset is synchronous and active high.

Top module: `proc_io_port`

## Requirements
- R1: While reset is high at a rising edge, the direction register loads 0xEF and the value register loads 0x37. The next reads return those values, and all three ROM/IO window flags read 1.
- R2: A read at offset 0 returns the direction register, and port_oe always equals the direction register.
- R3: A write at offset 0 replaces all eight direction bits and leaves the value register (port_out) unchanged.
- R4: A write at offset 1 stores new = (old AND NOT dir) OR (wdata AND dir). Input-direction bits keep their value.
- R5: A read at offset 1 returns the value register with bit 5 forced to 0 whenever direction bit 5 is 0. Otherwise it returns the register unchanged. The stored bit 5 on port_out is not altered by this masking.
- R6: Value bit 0 selects the 8 KB window at 0xA000: 1 sets win_lo_rom and clears win_lo_ram, 0 does the reverse.
- R7: Value bit 1 selects the 8 KB window at 0xE000: 1 sets win_hi_rom and clears win_hi_ram, 0 does the reverse.
- R8: Value bit 2 selects the 4 KB window at 0xD000: 1 sets win_d_io and clears win_d_chr, 0 does the reverse.
- R9: A write with cs low, or to any address other than 0 or 1, changes neither register. A read at any address other than 0 or 1 returns 0x00.
- R10: After a write edge, rdata, port_out, port_oe and the window flags show the new contents before the next rising edge, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select for the register bus |
| we | input | 1 | Write enable, qualified by cs |
| addr | input | AW (4) | Register offset: 0 direction, 1 value |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| port_out | output | 8 | Stored port value driven toward the lines |
| port_oe | output | 8 | Per-line output enable (direction register) |
| win_lo_rom | output | 1 | 0xA000 window maps ROM |
| win_lo_ram | output | 1 | 0xA000 window maps RAM |
| win_hi_rom | output | 1 | 0xE000 window maps ROM |
| win_hi_ram | output | 1 | 0xE000 window maps RAM |
| win_d_io | output | 1 | 0xD000 window maps IO devices |
| win_d_chr | output | 1 | 0xD000 window maps character ROM |

## Verification
The assertions assume that cs, we, addr and wdata hold known values at every rising edge, and that reset is high for at least one edge before any access. The bench drives every input to a defined level from time zero. It holds reset across several edges and changes inputs only one nanosecond after a rising edge, so the values seen at each edge are settled and never X. Reads are made with cs low, so a check can never also cause a write.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int unsigned IOP_DW = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DIR  = 2'd1,
    ACC_VAL  = 2'd2
  } iop_acc_e;

  function automatic logic [IOP_DW-1:0] merge_bits(
    input logic [IOP_DW-1:0] old_v,
    input logic [IOP_DW-1:0] new_v,
    input logic [IOP_DW-1:0] keep_new
  );
    return (old_v & ~keep_new) | (new_v & keep_new);
  endfunction
endpackage

// File: rtl/iop_addr_decode.sv
module iop_addr_decode
  import iop_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned OFS_DIR = 0,
  parameter int unsigned OFS_VAL = 1
) (
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output iop_acc_e      acc,
  output logic          wr_dir,
  output logic          wr_val
);
  localparam logic [AW-1:0] A_DIR = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_VAL = AW'(OFS_VAL);

  always_comb begin
    if (addr == A_DIR)      acc = ACC_DIR;
    else if (addr == A_VAL) acc = ACC_VAL;
    else                    acc = ACC_NONE;
  end

  assign wr_dir = cs && we && (acc == ACC_DIR);
  assign wr_val = cs && we && (acc == ACC_VAL);
endmodule

// File: rtl/iop_reg.sv
module iop_reg
  import iop_pkg::*;
#(
  parameter logic [IOP_DW-1:0] RST_VAL = '0,
  parameter bit                MASKED  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IOP_DW-1:0] wdata,
  input  logic [IOP_DW-1:0] wmask,
  output logic [IOP_DW-1:0] q
);
  logic [IOP_DW-1:0] nxt;

  generate
    if (MASKED) begin : g_masked
      assign nxt = merge_bits(q, wdata, wmask);

      AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask)))); // R4
      AST_MASKED_TAKE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((q & $past(wmask)) == ($past(wdata) & $past(wmask)))); // R4
    end else begin : g_plain
      logic [IOP_DW-1:0] unused_mask;
      assign unused_mask = wmask;
      assign nxt = wdata;

      AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(wdata))); // R3
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= nxt;
  end

  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == RST_VAL)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q)); // R9
endmodule

// File: rtl/iop_read_mux.sv
module iop_read_mux
  import iop_pkg::*;
#(
  parameter int unsigned SENSE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  iop_acc_e          acc,
  input  logic [IOP_DW-1:0] dir_q,
  input  logic [IOP_DW-1:0] val_q,
  output logic [IOP_DW-1:0] rdata
);
  logic [IOP_DW-1:0] val_view;

  always_comb begin
    val_view = val_q;
    if (!dir_q[SENSE_BIT]) val_view[SENSE_BIT] = 1'b0;
  end

  always_comb begin
    unique case (acc)
      ACC_DIR: rdata = dir_q;
      ACC_VAL: rdata = val_view;
      default: rdata = '0;
    endcase
  end

  AST_SENSE_LOW: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_VAL && !dir_q[SENSE_BIT]) |-> !rdata[SENSE_BIT]); // R5
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_NONE) |-> (rdata == '0)); // R9
endmodule

// File: rtl/iop_bank_decode.sv
module iop_bank_decode
  import iop_pkg::*;
#(
  parameter int unsigned LO_BIT = 0,
  parameter int unsigned HI_BIT = 1,
  parameter int unsigned CH_BIT = 2
) (
  input  logic [IOP_DW-1:0] val_q,
  output logic [2:0]        win_on,
  output logic [2:0]        win_off
);
  localparam int unsigned NWIN = 3;
  localparam int unsigned SEL_BIT [NWIN] = '{LO_BIT, HI_BIT, CH_BIT};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign win_on[g]  = val_q[SEL_BIT[g]];
    assign win_off[g] = ~val_q[SEL_BIT[g]];
  end
endmodule

// File: rtl/proc_io_port.sv
module proc_io_port
  import iop_pkg::*;
#(
  parameter int unsigned       AW        = 4,
  parameter logic [IOP_DW-1:0] DIR_RST   = 8'hEF,
  parameter logic [IOP_DW-1:0] VAL_RST   = 8'h37,
  parameter int unsigned       SENSE_BIT = 5,
  parameter int unsigned       LO_BIT    = 0,
  parameter int unsigned       HI_BIT    = 1,
  parameter int unsigned       CH_BIT    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [7:0]    port_out,
  output logic [7:0]    port_oe,
  output logic          win_lo_rom,
  output logic          win_lo_ram,
  output logic          win_hi_rom,
  output logic          win_hi_ram,
  output logic          win_d_io,
  output logic          win_d_chr
);
  iop_acc_e          acc;
  logic              wr_dir, wr_val;
  logic [IOP_DW-1:0] dir_q, val_q;
  logic [2:0]        win_on, win_off;

  iop_addr_decode #(.AW(AW), .OFS_DIR(0), .OFS_VAL(1)) u_dec (
    .cs(cs), .we(we), .addr(addr),
    .acc(acc), .wr_dir(wr_dir), .wr_val(wr_val)
  );

  iop_reg #(.RST_VAL(DIR_RST), .MASKED(1'b0)) u_dir (
    .clk(clk), .rst(rst), .wr_en(wr_dir),
    .wdata(wdata), .wmask('1), .q(dir_q)
  );

  iop_reg #(.RST_VAL(VAL_RST), .MASKED(1'b1)) u_val (
    .clk(clk), .rst(rst), .wr_en(wr_val),
    .wdata(wdata), .wmask(dir_q), .q(val_q)
  );

  iop_read_mux #(.SENSE_BIT(SENSE_BIT)) u_rd (
    .clk(clk), .rst(rst), .acc(acc),
    .dir_q(dir_q), .val_q(val_q), .rdata(rdata)
  );

  iop_bank_decode #(.LO_BIT(LO_BIT), .HI_BIT(HI_BIT), .CH_BIT(CH_BIT)) u_bank (
    .val_q(val_q), .win_on(win_on), .win_off(win_off)
  );

  assign port_out   = val_q;
  assign port_oe    = dir_q;
  assign win_lo_rom = win_on[0];
  assign win_lo_ram = win_off[0];
  assign win_hi_rom = win_on[1];
  assign win_hi_ram = win_off[1];
  assign win_d_io   = win_on[2];
  assign win_d_chr  = win_off[2];

  AST_DIR_WRITE_KEEPS_VAL: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> $stable(port_out)); // R3
  AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_val && dir_q[LO_BIT]) |=> (win_lo_rom == $past(wdata[LO_BIT]) && win_lo_ram != win_lo_rom)); // R6
  AST_HI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_val && dir_q[HI_BIT]) |=> (win_hi_rom == $past(wdata[HI_BIT]) && win_hi_ram != win_hi_rom)); // R7
  AST_D_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_val && dir_q[CH_BIT]) |=> (win_d_io == $past(wdata[CH_BIT]) && win_d_chr != win_d_io)); // R8
  AST_OE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_DIR) |-> (rdata == port_oe)); // R2
endmodule

// File: tb/test_proc_io_port.sv
`timescale 1ns/1ps
module test_proc_io_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs  = 1'b0;
  logic       we  = 1'b0;
  logic [3:0] addr  = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, port_out, port_oe;
  logic win_lo_rom, win_lo_ram, win_hi_rom, win_hi_ram, win_d_io, win_d_chr;

  always #2.5 clk = ~clk;

  proc_io_port i_proc_io_port (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .port_out(port_out), .port_oe(port_oe),
    .win_lo_rom(win_lo_rom), .win_lo_ram(win_lo_ram),
    .win_hi_rom(win_hi_rom), .win_hi_ram(win_hi_ram),
    .win_d_io(win_d_io), .win_d_chr(win_d_chr)
  );

  typedef struct {
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_dir = 8'hEF;
  logic [7:0] m_val = 8'h37;

  function automatic logic [7:0] model_read(input logic [3:0] a);
    if (a == 4'd0) return m_dir;
    if (a == 4'd1) return m_dir[5] ? m_val : (m_val & 8'hDF);
    return 8'h00;
  endfunction

  // Monitor: pops one expected vector per falling edge and compares.
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      sb_item_t it;
      logic [31:0] obs;
      it  = sbq.pop_front();
      obs = {rdata, port_out, port_oe, 2'b00,
             win_d_chr, win_d_io, win_hi_ram, win_hi_rom, win_lo_ram, win_lo_rom};
      n_chk++;
      if (obs !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, obs, it.exp);
      end
    end
  end

  // Driver: a read cycle with cs low, expectation pushed to the scoreboard.
  task automatic chk(input logic [3:0] a, input string req);
    sb_item_t it;
    addr = a; cs = 1'b0; we = 1'b0;
    it.exp = {model_read(a), m_val, m_dir, 2'b00,
              ~m_val[2], m_val[2], ~m_val[1], m_val[1], ~m_val[0], m_val[0]};
    it.req = req;
    sbq.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d,
                    input logic c = 1'b1, input logic w = 1'b1);
    addr = a; wdata = d; cs = c; we = w;
    @(posedge clk); #1;
    cs = 1'b0; we = 1'b0;
    if (c && w) begin
      if (a == 4'd0)      m_dir = d;
      else if (a == 4'd1) m_val = (m_val & ~m_dir) | (d & m_dir);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    m_dir = 8'hEF; m_val = 8'h37;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(4'd0, "R1 R2 reset direction");
    chk(4'd1, "R1 reset value, windows high");
    // R5: clear direction bit 5, value bit 5 must read 0 but stay stored
    wr(4'd0, 8'hCF);
    chk(4'd0, "R3 direction replaced");
    chk(4'd1, "R5 bit5 masked while input");
    wr(4'd0, 8'hFF);
    chk(4'd1, "R5 bit5 visible again");
    // R4: zero write under reset direction clears only outputs
    wr(4'd0, 8'hEF);
    wr(4'd1, 8'h00);
    chk(4'd1, "R4 R10 zero write under 0xEF");
    wr(4'd1, 8'hFF);
    chk(4'd1, "R4 ones write under 0xEF");
    wr(4'd1, 8'h01);
    chk(4'd1, "R6 low window ROM");
    wr(4'd1, 8'h02);
    chk(4'd1, "R7 high window ROM");
    wr(4'd1, 8'h04);
    chk(4'd1, "R8 D window IO");
    wr(4'd0, 8'hF0);
    wr(4'd1, 8'hA5);
    chk(4'd1, "R4 upper nibble only");
    chk(4'd0, "R2 direction 0xF0");
    // R9: ignored writes
    wr(4'd1, 8'h00, 1'b0, 1'b1);
    chk(4'd1, "R9 cs low write ignored");
    wr(4'd5, 8'h00);
    chk(4'd1, "R9 other address write ignored");
    chk(4'd0, "R9 direction kept");
    chk(4'd5, "R9 other address reads zero");
    wr(4'd0, 8'h00);
    wr(4'd1, 8'hFF);
    chk(4'd1, "R4 all inputs, write ignored");
    wr(4'd0, 8'h07);
    wr(4'd1, 8'h00);
    chk(4'd1, "R6 R7 R8 all windows RAM/char");
    wr(4'd0, 8'h5A);
    do_reset();
    chk(4'd0, "R1 reset again direction");
    chk(4'd1, "R1 reset again value");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule